// File: doc/BRIEF.md
# Sequential Expected-Value Checker

This block walks through a fixed list of expected samples, moving one entry per clock, and compares each entry with a live data input. The list is a compile-time parameter. When the input differs from the current entry, the block raises a one-cycle registered mismatch pulse. The pulse comes with registered copies of the expected value and the actual value from the compare that failed. A sticky error flag records that at least one mismatch has occurred since reset. A done flag rises once every entry has been used.

After the list runs out, the entry pointer stays on the last entry. From then on, every later sample is compared against that final expected value, for as long as the block runs.

The block also carries an unrelated signal straight through from input to output. This lets it be dropped inline into a design without changing that signal. A testbench or an on-chip monitor can log the registered mismatch ports.

Top module: `seqchk_top`

## Requirements
- R1: While `rst` is high, at each rising clock edge the pointer returns to entry 0 and `mism_o`, `done_o` and `err_o` are cleared. The first edge with `rst` low compares against entry 0.
- R2: At each rising edge with `rst` low, `data_i` is compared with the table entry at the pointer. In the following cycle `mism_o` is high for exactly one cycle if they differ, and low if they are equal.
- R3: After each compare, `exp_o` holds the table entry that was used and `act_o` holds the sampled `data_i`. The expected value never appears on `act_o`, and the actual value never appears on `exp_o`.
- R4: `done_o` stays low until `DEPTH` samples have been compared since reset, whether or not they matched. It goes high in the cycle after the `DEPTH`-th compare and stays high until reset.
- R5: Once the table is exhausted, the pointer stays on entry `DEPTH-1`. Every later sample is compared against that final entry.
- R6: `err_o` rises together with the first `mism_o` pulse after reset and stays high until reset.
- R7: `thru_o` equals `thru_i` at all times, with no register in between.
- R8: Table entry i is taken from bits [i*W +: W] of the `TABLE` parameter. Entry 0 is the first one checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | W | Monitored value under test |
| thru_i | input | W | Signal carried through unaltered |
| thru_o | output | W | Copy of `thru_i` |
| mism_o | output | 1 | One-cycle pulse: the last compare failed |
| exp_o | output | W | Expected table entry of the last compare |
| act_o | output | W | Sampled input of the last compare |
| done_o | output | 1 | All table entries consumed |
| err_o | output | 1 | Sticky: a mismatch has occurred since reset |

## Verification
The hardest situation to reach is the period after the table is exhausted. Only there does the sticking pointer matter, and a wrong final entry or a wrapping pointer would show up there. The stimulus first replays a run with mixed matches and mismatches past the end of the table. It then resets in the middle of a run and replays a fully matching run. Finally it drives, after done, values both equal to and different from the last entry. This shows that mismatches are still reported against the held entry and that the sticky and done flags do not fall until reset.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    localparam int DEF_W     = 8;
    localparam int DEF_DEPTH = 10;

    // Entry i sits at bits [i*W +: W]; entry 0 is the lowest byte.
    localparam logic [DEF_DEPTH*DEF_W-1:0] DEF_TABLE = {
        8'd10, 8'd9, 8'd8, 8'd7, 8'd5,
        8'd4,  8'd3, 8'd2, 8'd99, 8'd70
    };

    // Width of a counter able to hold 0..depth.
    function automatic int ptr_width(input int depth);
        return (depth < 1) ? 1 : $clog2(depth + 1);
    endfunction

    typedef enum logic {
        WALKING = 1'b0,
        HOLDING = 1'b1
    } walk_state_e;

endpackage

// File: rtl/seqchk_ptr.sv
module seqchk_ptr #(
    parameter int DEPTH = 10,
    parameter int PW    = seqchk_pkg::ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] ptr_o,
    output logic          done_o
);
    import seqchk_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    walk_state_e  state_q;
    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            state_q <= WALKING;
        end else if (state_q == WALKING) begin
            if (ptr_q == LAST) begin
                state_q <= HOLDING;
            end else begin
                ptr_q <= ptr_q + PW'(1);
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign done_o = (state_q == HOLDING);

endmodule

// File: rtl/seqchk_cmp.sv
module seqchk_cmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] act_i,
    output logic         mism_o,
    output logic [W-1:0] exp_o,
    output logic [W-1:0] act_o,
    output logic         err_o
);
    logic differ;

    assign differ = (exp_i != act_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mism_o <= 1'b0;
            exp_o  <= '0;
            act_o  <= '0;
            err_o  <= 1'b0;
        end else begin
            mism_o <= differ;
            exp_o  <= exp_i;
            act_o  <= act_i;
            err_o  <= err_o | differ;
        end
    end

endmodule

// File: rtl/seqchk_top.sv
module seqchk_top #(
    parameter int                 W     = seqchk_pkg::DEF_W,
    parameter int                 DEPTH = seqchk_pkg::DEF_DEPTH,
    parameter logic [DEPTH*W-1:0] TABLE = seqchk_pkg::DEF_TABLE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] thru_i,
    output logic [W-1:0] thru_o,
    output logic         mism_o,
    output logic [W-1:0] exp_o,
    output logic [W-1:0] act_o,
    output logic         done_o,
    output logic         err_o
);
    localparam int PW = seqchk_pkg::ptr_width(DEPTH);

    logic [PW-1:0] ptr;
    logic [W-1:0]  entry [DEPTH];
    logic [W-1:0]  exp_sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entry[g] = TABLE[g*W +: W];
    end

    always_comb begin
        exp_sel = entry[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (ptr == PW'(i)) exp_sel = entry[i];
        end
    end

    seqchk_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ptr_o  (ptr),
        .done_o (done_o)
    );

    seqchk_cmp #(.W(W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .exp_i  (exp_sel),
        .act_i  (data_i),
        .mism_o (mism_o),
        .exp_o  (exp_o),
        .act_o  (act_o),
        .err_o  (err_o)
    );

    assign thru_o = thru_i;

endmodule

// File: rtl/seqchk_sva.sv
module seqchk_sva #(
    parameter int W     = 8,
    parameter int DEPTH = 10
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] data_i,
    input logic [W-1:0] thru_i,
    input logic [W-1:0] thru_o,
    input logic         mism_o,
    input logic [W-1:0] exp_o,
    input logic [W-1:0] act_o,
    input logic         done_o,
    input logic         err_o
);
    localparam int CW = seqchk_pkg::ptr_width(DEPTH) + 1;

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else if (seen_q < CW'(DEPTH)) seen_q <= seen_q + CW'(1);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!mism_o && !done_o && !err_o));

    // R2
    mism_differs_chk: assert property (@(posedge clk) disable iff (rst)
        mism_o |-> (exp_o != act_o));

    // R3
    act_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (act_o == $past(data_i)));

    // R4
    done_early_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (seen_q >= CW'(DEPTH)));

    // R4
    done_due_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q >= CW'(DEPTH)) |-> done_o);

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    // R5
    exp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(done_o)) |-> $stable(exp_o));

    // R6
    err_follows_chk: assert property (@(posedge clk) disable iff (rst)
        mism_o |-> err_o);

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R7
    always_comb begin
        thru_same_chk: assert (thru_o == thru_i);
    end

endmodule

bind seqchk_top seqchk_sva #(.W(W), .DEPTH(DEPTH)) u_sva (
    .clk    (clk),
    .rst    (rst),
    .data_i (data_i),
    .thru_i (thru_i),
    .thru_o (thru_o),
    .mism_o (mism_o),
    .exp_o  (exp_o),
    .act_o  (act_o),
    .done_o (done_o),
    .err_o  (err_o)
);

// File: tb/tb_seqchk_top.sv
module tb_seqchk_top;

    localparam int W = 8;
    localparam int N = 10;
    localparam int EXP_TBL [N] = '{70, 99, 2, 3, 4, 5, 7, 8, 9, 10};

    typedef struct {
        logic         mism;
        logic [W-1:0] expv;
        logic [W-1:0] actv;
        logic         done;
        logic         err;
        logic         held;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] thru_i = '0;
    logic [W-1:0] thru_o, exp_o, act_o;
    logic mism_o, done_o, err_o;

    int n_tests = 0;
    int n_fail  = 0;
    item_t q[$];
    int  m_idx  = 0;
    logic m_done = 1'b0;
    logic m_err  = 1'b0;

    always #5 clk = ~clk;

    seqchk_top dut (
        .clk(clk), .rst(rst), .data_i(data_i), .thru_i(thru_i),
        .thru_o(thru_o), .mism_o(mism_o), .exp_o(exp_o), .act_o(act_o),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; leaves at the following negedge.
    task automatic drive(input int v);
        item_t it;
        data_i  = W'(v);
        it.held = m_done;
        it.expv = W'(EXP_TBL[m_idx]);
        it.actv = W'(v);
        it.mism = (it.expv != it.actv);
        if (m_idx == N - 1) m_done = 1'b1;
        else m_idx++;
        m_err   = m_err | it.mism;
        it.done = m_done;
        it.err  = m_err;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_idx = 0; m_done = 1'b0; m_err = 1'b0;
        @(posedge clk); #2;
        chk(!mism_o, "R1 mism", int'(mism_o), 0);
        chk(!done_o, "R1 done", int'(done_o), 0);
        chk(!err_o,  "R1 err",  int'(err_o),  0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: pops one expected item per compare.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(mism_o == it.mism, "R2 mism", int'(mism_o), int'(it.mism));
            chk(exp_o == it.expv, it.held ? "R5 exp" : "R3 R8 exp", int'(exp_o), int'(it.expv));
            chk(act_o == it.actv, "R3 act", int'(act_o), int'(it.actv));
            chk(done_o == it.done, "R4 done", int'(done_o), int'(it.done));
            chk(err_o == it.err, "R6 err", int'(err_o), int'(it.err));
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                do_reset();
                // Mixed run: 0..10 then repeated 10s past the end of the table
                for (int i = 0; i <= 10; i++) drive(i);
                repeat (3) drive(10);
                // R5: after done, a differing value still mismatches against the last entry
                drive(11);
                drive(10);
                // Reset mid-run, then a fully matching run (R1, R4, R6)
                drive(70); drive(99); drive(1);
                do_reset();
                for (int i = 0; i < N; i++) drive(EXP_TBL[i]);
                drive(10);
                drive(0);
                @(negedge clk); @(negedge clk);
                // R7: pass-through, no register
                for (int v = 0; v < 256; v += 37) begin
                    thru_i = W'(v);
                    #1;
                    chk(thru_o == W'(v), "R7 thru", int'(thru_o), v);
                end
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule